// File: doc/BRIEF.md
# I2C Command-Addressed Register Interface

This block is an I2C target that gives a bus controller access to the configuration and result registers of a light-sensing core. The target answers to one fixed 7-bit address. Every write transaction opens with a command byte. That byte either sets a stored register pointer together with an addressing mode, or it triggers a special function such as clearing the pending interrupt. Data bytes that follow, and any later reads, act at the stored pointer. The pointer either stays on one register or steps forward after each byte.

The configuration bytes are held inside the block and driven onto output ports for the core. The core supplies two 16-bit channel counts and two status flags, which are readable on the bus. Reading the low byte of a channel count freezes that channel's high byte in a shadow latch, so a two-byte read always returns a matched pair. SCL and SDA are sampled through synchronizers on the system clock. The block drives SDA only by pulling it low through an output-enable.

Top module: `i2c_cmd_regif`

## Requirements
- R1: Only the 7-bit address 0x39 is acknowledged, by pulling SDA low in the ninth bit. Any other address is not acknowledged, and the data that follows it changes no register.
- R2: A first write byte with bit 7 set is a command. Bits 6:5 give its type. Type 00 or 01 loads bits 4:0 into the stored pointer and writes no register.
- R3: After a type 00 command, every data byte of a transaction is written to, or read from, the same register.
- R4: After a type 01 command, the pointer increases by one, wrapping within 5 bits, after each data byte written or read.
- R5: A type 11 command with bits 4:0 equal to 00110 pulses int_clr_o for exactly one clock. Code 00000 produces no pulse. Type 10 is ignored. None of these changes the pointer.
- R6: A first write byte with bit 7 clear is stored as data at the current pointer.
- R7: A read that has no preceding command uses the pointer left by earlier transactions. The pointer survives stop conditions.
- R8: Reading 0x14 (or 0x16) copies ch0_i[15:8] (or ch1_i[15:8]) into a shadow latch. A later read of 0x15 (or 0x17) returns that latched byte, even if the input has changed since.
- R9: The writable bytes are enable 0x00, integration time 0x01, wait time 0x03, low threshold 0x04/0x05 (low byte first), high threshold 0x06/0x07, persistence 0x0C, config 0x0D and gain 0x0F. Each is driven on its own output port. Integration time and wait time reset to 0xFF; the others reset to 0x00.
- R10: Address 0x12 reads 0x34. Address 0x13 reads aint_i at bit 4 and avalid_i at bit 0, with every other bit 0. Addresses 0x14 and 0x16 read the channel low bytes. Unmapped addresses read 0x00. Writes to read-only or unmapped addresses have no effect.
- R11: start_o pulses for one clock on each start and repeated start. A stop returns the target to idle with SDA released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe_o | output | 1 | Pull SDA low when 1 |
| start_o | output | 1 | One-clock pulse on start or repeated start |
| int_clr_o | output | 1 | One-clock interrupt clear strobe |
| ch0_i | input | 16 | Channel 0 result from the core |
| ch1_i | input | 16 | Channel 1 result from the core |
| aint_i | input | 1 | Interrupt pending flag from the core |
| avalid_i | input | 1 | Result valid flag from the core |
| enable_o | output | 8 | Enable register |
| atime_o | output | 8 | Integration time register |
| wtime_o | output | 8 | Wait time register |
| thr_lo_o | output | 16 | Low threshold |
| thr_hi_o | output | 16 | High threshold |
| pers_o | output | 8 | Persistence register |
| config_o | output | 8 | Config register |
| gain_o | output | 8 | Gain control register |

## Verification
An SCL or SDA change reaches the engine after two synchronizer flops and one edge-detect flop, so the target's SDA response is registered three to four clocks after the SCL fall that triggers it. The bench holds each SCL phase for ten clocks and samples SDA in the middle of the high phase, well after that response has settled. A written byte reaches its output port one clock after the write strobe. That strobe fires at the SCL fall that ends the eighth data bit, so the bench compares register ports only after the stop condition. The start and interrupt-clear pulses each last one clock, and the bench counts them on falling clock edges so that none is missed or counted twice.

// File: rtl/i2c_regif_pkg.sv
package i2c_regif_pkg;

  typedef enum logic [3:0] {
    ST_IDLE, ST_ADDR, ST_ADDR_END, ST_ADDR_ACK,
    ST_WR, ST_WR_END, ST_WR_ACK,
    ST_RD, ST_RD_END, ST_RD_ACK
  } bus_st_e;

  localparam int unsigned PTR_W = 5;

  localparam logic [1:0] CMD_REPEAT  = 2'b00;
  localparam logic [1:0] CMD_AUTOINC = 2'b01;
  localparam logic [1:0] CMD_SPECIAL = 2'b11;
  localparam logic [4:0] SF_INT_CLR  = 5'b00110;

  localparam logic [4:0] A_ID     = 5'h12;
  localparam logic [4:0] A_STATUS = 5'h13;
  localparam logic [4:0] A_CH0L   = 5'h14;
  localparam logic [4:0] A_CH0H   = 5'h15;
  localparam logic [4:0] A_CH1L   = 5'h16;
  localparam logic [4:0] A_CH1H   = 5'h17;

  // writable bytes: enable, atime, wtime, thr lo L/H, thr hi L/H, pers, config, gain
  localparam int unsigned NCFG = 10;
  localparam logic [4:0] CFG_ADDR [NCFG] = '{5'h00, 5'h01, 5'h03, 5'h04, 5'h05,
                                              5'h06, 5'h07, 5'h0C, 5'h0D, 5'h0F};
  localparam logic [7:0] CFG_RST  [NCFG] = '{8'h00, 8'hFF, 8'hFF, 8'h00, 8'h00,
                                              8'h00, 8'h00, 8'h00, 8'h00, 8'h00};

endpackage

// File: rtl/i2c_bus_sync.sv
module i2c_bus_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);

  logic [STAGES-1:0] scl_ff, sda_ff;
  logic              scl_q, sda_q;
  logic              scl_s, sda_s;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_ff <= '1;
      sda_ff <= '1;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[STAGES-2:0], scl_i};
      sda_ff <= {sda_ff[STAGES-2:0], sda_i};
      scl_q  <= scl_s;
      sda_q  <= sda_s;
    end
  end

  assign scl_s      = scl_ff[STAGES-1];
  assign sda_s      = sda_ff[STAGES-1];
  assign sda_o      = sda_s;
  assign scl_rise_o = scl_s & ~scl_q;
  assign scl_fall_o = ~scl_s & scl_q;
  assign start_o    = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_o     = scl_s & scl_q & ~sda_q & sda_s;

endmodule

// File: rtl/i2c_target_fsm.sv
module i2c_target_fsm
  import i2c_regif_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h39
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       sda_i,
  input  logic       scl_rise_i,
  input  logic       scl_fall_i,
  input  logic       start_i,
  input  logic       stop_i,
  output logic       sda_oe_o,
  output logic       wr_stb_o,
  output logic       wr_first_o,
  output logic [7:0] wr_data_o,
  output logic       rd_stb_o,
  input  logic [7:0] rd_data_i
);

  bus_st_e    st_q;
  logic [2:0] cnt_q;
  logic [7:0] sr_q, tx_q;
  logic       rw_q, first_q, more_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= ST_IDLE;
      cnt_q    <= '0;
      sr_q     <= '0;
      tx_q     <= '0;
      rw_q     <= 1'b0;
      first_q  <= 1'b0;
      more_q   <= 1'b0;
      sda_oe_o <= 1'b0;
      wr_stb_o <= 1'b0;
      rd_stb_o <= 1'b0;
    end else begin
      wr_stb_o <= 1'b0;
      rd_stb_o <= 1'b0;
      if (stop_i) begin
        st_q     <= ST_IDLE;
        sda_oe_o <= 1'b0;
      end else if (start_i) begin
        st_q     <= ST_ADDR;
        cnt_q    <= '0;
        sda_oe_o <= 1'b0;
      end else begin
        unique case (st_q)
          ST_ADDR, ST_WR: if (scl_rise_i) begin
            sr_q  <= {sr_q[6:0], sda_i};
            cnt_q <= cnt_q + 3'd1;
            if (cnt_q == 3'd7) st_q <= (st_q == ST_ADDR) ? ST_ADDR_END : ST_WR_END;
          end
          ST_ADDR_END: if (scl_fall_i) begin
            if (sr_q[7:1] == DEV_ADDR) begin
              sda_oe_o <= 1'b1;
              rw_q     <= sr_q[0];
              st_q     <= ST_ADDR_ACK;
            end else begin
              st_q <= ST_IDLE;
            end
          end
          ST_ADDR_ACK: if (scl_fall_i) begin
            cnt_q <= '0;
            if (rw_q) begin
              tx_q     <= rd_data_i;
              sda_oe_o <= ~rd_data_i[7];
              rd_stb_o <= 1'b1;
              st_q     <= ST_RD;
            end else begin
              sda_oe_o <= 1'b0;
              first_q  <= 1'b1;
              st_q     <= ST_WR;
            end
          end
          ST_WR_END: if (scl_fall_i) begin
            sda_oe_o <= 1'b1;
            wr_stb_o <= 1'b1;
            st_q     <= ST_WR_ACK;
          end
          ST_WR_ACK: if (scl_fall_i) begin
            sda_oe_o <= 1'b0;
            first_q  <= 1'b0;
            cnt_q    <= '0;
            st_q     <= ST_WR;
          end
          ST_RD: begin
            if (scl_rise_i) begin
              cnt_q <= cnt_q + 3'd1;
              if (cnt_q == 3'd7) st_q <= ST_RD_END;
            end
            if (scl_fall_i) begin
              tx_q     <= {tx_q[6:0], 1'b0};
              sda_oe_o <= ~tx_q[6];
            end
          end
          ST_RD_END: if (scl_fall_i) begin
            sda_oe_o <= 1'b0;
            st_q     <= ST_RD_ACK;
          end
          ST_RD_ACK: begin
            if (scl_rise_i) more_q <= ~sda_i;
            if (scl_fall_i) begin
              cnt_q <= '0;
              if (more_q) begin
                tx_q     <= rd_data_i;
                sda_oe_o <= ~rd_data_i[7];
                rd_stb_o <= 1'b1;
                st_q     <= ST_RD;
              end else begin
                st_q <= ST_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign wr_first_o = first_q;
  assign wr_data_o  = sr_q;

  AST_STOP_RELEASES_SDA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i |=> !sda_oe_o); // R11
  AST_IDLE_NO_DRIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_IDLE) |-> !sda_oe_o); // R1
  AST_STB_EXCLUSIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_stb_o && rd_stb_o)); // R4

endmodule

// File: rtl/regif_regfile.sv
module regif_regfile
  import i2c_regif_pkg::*;
#(
  parameter logic [7:0] ID_VAL = 8'h34
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_stb_i,
  input  logic        wr_first_i,
  input  logic [7:0]  wr_data_i,
  input  logic        rd_stb_i,
  output logic [7:0]  rd_data_o,
  output logic        int_clr_o,
  input  logic [15:0] ch0_i,
  input  logic [15:0] ch1_i,
  input  logic        aint_i,
  input  logic        avalid_i,
  output logic [7:0]  cfg_o [NCFG]
);

  logic [PTR_W-1:0] ptr_q;
  logic             auto_q;
  logic [7:0]       sh0_q, sh1_q;
  logic [7:0]       cfg_q [NCFG];
  logic             is_cmd, data_wr;

  assign is_cmd  = wr_stb_i & wr_first_i & wr_data_i[7];
  assign data_wr = wr_stb_i & ~(wr_first_i & wr_data_i[7]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q     <= '0;
      auto_q    <= 1'b0;
      sh0_q     <= '0;
      sh1_q     <= '0;
      int_clr_o <= 1'b0;
    end else begin
      int_clr_o <= 1'b0;
      if (is_cmd) begin
        unique case (wr_data_i[6:5])
          CMD_REPEAT, CMD_AUTOINC: begin
            ptr_q  <= wr_data_i[4:0];
            auto_q <= wr_data_i[5];
          end
          CMD_SPECIAL: if (wr_data_i[4:0] == SF_INT_CLR) int_clr_o <= 1'b1;
          default: ;
        endcase
      end else if (data_wr) begin
        if (auto_q) ptr_q <= ptr_q + 1'b1;
      end else if (rd_stb_i) begin
        if (auto_q) ptr_q <= ptr_q + 1'b1;
        if (ptr_q == A_CH0L) sh0_q <= ch0_i[15:8];
        if (ptr_q == A_CH1L) sh1_q <= ch1_i[15:8];
      end
    end
  end

  for (genvar g = 0; g < NCFG; g++) begin : g_cfg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                             cfg_q[g] <= CFG_RST[g];
      else if (data_wr && ptr_q == CFG_ADDR[g]) cfg_q[g] <= wr_data_i;
    end
    assign cfg_o[g] = cfg_q[g];
  end

  always_comb begin
    rd_data_o = '0;
    for (int i = 0; i < NCFG; i++)
      if (ptr_q == CFG_ADDR[i]) rd_data_o = cfg_q[i];
    unique case (ptr_q)
      A_ID:     rd_data_o = ID_VAL;
      A_STATUS: rd_data_o = {3'b000, aint_i, 3'b000, avalid_i};
      A_CH0L:   rd_data_o = ch0_i[7:0];
      A_CH0H:   rd_data_o = sh0_q;
      A_CH1L:   rd_data_o = ch1_i[7:0];
      A_CH1H:   rd_data_o = sh1_q;
      default: ;
    endcase
  end

  AST_INT_CLR_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int_clr_o |=> !int_clr_o); // R5
  AST_SPECIAL_KEEPS_PTR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_cmd && wr_data_i[6]) |=> $stable(ptr_q)); // R5
  AST_PTR_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_stb_i && !rd_stb_i) |=> $stable(ptr_q)); // R7
  AST_SHADOW0_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rd_stb_i && ptr_q == A_CH0L) |=> $stable(sh0_q)); // R8
  AST_SHADOW1_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rd_stb_i && ptr_q == A_CH1L) |=> $stable(sh1_q)); // R8

endmodule

// File: rtl/i2c_cmd_regif.sv
module i2c_cmd_regif
  import i2c_regif_pkg::*;
#(
  parameter logic [6:0]  DEV_ADDR    = 7'h39,
  parameter logic [7:0]  ID_VAL      = 8'h34,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        scl_i,
  input  logic        sda_i,
  output logic        sda_oe_o,
  output logic        start_o,
  output logic        int_clr_o,
  input  logic [15:0] ch0_i,
  input  logic [15:0] ch1_i,
  input  logic        aint_i,
  input  logic        avalid_i,
  output logic [7:0]  enable_o,
  output logic [7:0]  atime_o,
  output logic [7:0]  wtime_o,
  output logic [15:0] thr_lo_o,
  output logic [15:0] thr_hi_o,
  output logic [7:0]  pers_o,
  output logic [7:0]  config_o,
  output logic [7:0]  gain_o
);

  logic       sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic       wr_stb, wr_first, rd_stb;
  logic [7:0] wr_data, rd_data;
  logic [7:0] cfg [NCFG];

  i2c_bus_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .scl_i, .sda_i,
    .sda_o(sda_s), .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .start_o(start_det), .stop_o(stop_det)
  );

  i2c_target_fsm #(.DEV_ADDR(DEV_ADDR)) u_fsm (
    .clk_i, .rst_ni, .sda_i(sda_s),
    .scl_rise_i(scl_rise), .scl_fall_i(scl_fall),
    .start_i(start_det), .stop_i(stop_det),
    .sda_oe_o, .wr_stb_o(wr_stb), .wr_first_o(wr_first), .wr_data_o(wr_data),
    .rd_stb_o(rd_stb), .rd_data_i(rd_data)
  );

  regif_regfile #(.ID_VAL(ID_VAL)) u_rf (
    .clk_i, .rst_ni,
    .wr_stb_i(wr_stb), .wr_first_i(wr_first), .wr_data_i(wr_data),
    .rd_stb_i(rd_stb), .rd_data_o(rd_data), .int_clr_o,
    .ch0_i, .ch1_i, .aint_i, .avalid_i, .cfg_o(cfg)
  );

  assign start_o  = start_det;
  assign enable_o = cfg[0];
  assign atime_o  = cfg[1];
  assign wtime_o  = cfg[2];
  assign thr_lo_o = {cfg[4], cfg[3]};
  assign thr_hi_o = {cfg[6], cfg[5]};
  assign pers_o   = cfg[7];
  assign config_o = cfg[8];
  assign gain_o   = cfg[9];

endmodule

// File: tb/i2c_cmd_regif_tb.sv
module i2c_cmd_regif_tb;

  localparam int Q = 5;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic sda_oe, start_p, int_clr;
  logic [15:0] ch0 = 16'hBEEF, ch1 = 16'h1234;
  logic aint = 1'b1, avalid = 1'b1;
  logic [7:0] enable_o, atime_o, wtime_o, pers_o, config_o, gain_o;
  logic [15:0] thr_lo_o, thr_hi_o;
  wire sda_line = sda_m & ~sda_oe;

  always #10 clk = ~clk;

  i2c_cmd_regif u_dut (
    .clk_i(clk), .rst_ni, .scl_i(scl_m), .sda_i(sda_line), .sda_oe_o(sda_oe),
    .start_o(start_p), .int_clr_o(int_clr), .ch0_i(ch0), .ch1_i(ch1),
    .aint_i(aint), .avalid_i(avalid), .enable_o, .atime_o, .wtime_o,
    .thr_lo_o, .thr_hi_o, .pers_o, .config_o, .gain_o
  );

  int nchk = 0, nerr = 0;
  int n_start = 0, n_clr = 0;
  logic [7:0] mdl [32];
  logic [7:0] txb [40];
  logic [7:0] rxb [40];

  always @(negedge clk) begin
    if (start_p) n_start++;
    if (int_clr) n_clr++;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bit_out(input logic b);
    sda_m = b; tick(2*Q); scl_m = 1'b1; tick(2*Q); scl_m = 1'b0;
  endtask

  task automatic bit_in(output logic b);
    sda_m = 1'b1; tick(2*Q); scl_m = 1'b1; tick(Q); b = sda_line; tick(Q); scl_m = 1'b0;
  endtask

  task automatic i2c_start();
    sda_m = 1'b1; tick(Q); scl_m = 1'b1; tick(Q); sda_m = 1'b0; tick(Q); scl_m = 1'b0; tick(Q);
  endtask

  task automatic i2c_stop();
    sda_m = 1'b0; tick(Q); scl_m = 1'b1; tick(Q); sda_m = 1'b1; tick(2*Q);
  endtask

  task automatic send_byte(input logic [7:0] d, output logic ack);
    logic a;
    for (int i = 7; i >= 0; i--) bit_out(d[i]);
    bit_in(a);
    ack = ~a;
  endtask

  task automatic recv_byte(output logic [7:0] d, input logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) begin bit_in(b); d[i] = b; end
    bit_out(~ack);
  endtask

  task automatic do_write(input int n);
    logic ack;
    i2c_start();
    send_byte({7'h39, 1'b0}, ack);
    for (int i = 0; i < n; i++) send_byte(txb[i], ack);
    i2c_stop();
  endtask

  task automatic do_read(input int n);
    logic ack;
    i2c_start();
    send_byte({7'h39, 1'b1}, ack);
    for (int i = 0; i < n; i++) recv_byte(rxb[i], i < n - 1);
    i2c_stop();
  endtask

  task automatic do_cmd_read(input logic [7:0] cmd, input int n);
    logic ack;
    i2c_start();
    send_byte({7'h39, 1'b0}, ack);
    send_byte(cmd, ack);
    i2c_start();
    send_byte({7'h39, 1'b1}, ack);
    for (int i = 0; i < n; i++) recv_byte(rxb[i], i < n - 1);
    i2c_stop();
  endtask

  function automatic logic is_cfg(input int a);
    return a == 0 || a == 1 || a == 3 || (a >= 4 && a <= 7) || a == 12 || a == 13 || a == 15;
  endfunction

  function automatic logic [7:0] exp_rd(input int a);
    if (is_cfg(a)) return mdl[a];
    case (a)
      18: return 8'h34;
      19: return {3'b0, aint, 3'b0, avalid};
      20: return ch0[7:0];
      21: return ch0[15:8];
      22: return ch1[7:0];
      23: return ch1[15:8];
      default: return 8'h00;
    endcase
  endfunction

  task automatic chk_ports(input string req);
    chk(req, enable_o, mdl[0]);
    chk(req, atime_o, mdl[1]);
    chk(req, wtime_o, mdl[3]);
    chk(req, thr_lo_o, {mdl[5], mdl[4]});
    chk(req, thr_hi_o, {mdl[7], mdl[6]});
    chk(req, pers_o, mdl[12]);
    chk(req, config_o, mdl[13]);
    chk(req, gain_o, mdl[15]);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    logic ack;
    int s0, c0;
    for (int i = 0; i < 32; i++) mdl[i] = 8'h00;
    mdl[1] = 8'hFF; mdl[3] = 8'hFF;
    tick(5); rst_ni = 1'b1; tick(5);

    // R9 reset values
    chk_ports("R9 reset");
    chk("R11 reset sda released", sda_oe, 1'b0);

    // R1 address sweep
    for (int a = 0; a < 128; a++) begin
      i2c_start();
      send_byte({a[6:0], 1'b0}, ack);
      i2c_stop();
      chk("R1 address ack", ack, a == 7'h39);
    end

    // R2/R4/R9/R10 write sweep with auto-increment from 0x00
    txb[0] = 8'hA0;
    for (int i = 0; i < 32; i++) txb[i+1] = 8'((i * 37 + 11) & 8'hFF);
    do_write(33);
    for (int i = 0; i < 32; i++) if (is_cfg(i)) mdl[i] = txb[i+1];
    chk_ports("R4 R9 autoinc write");

    // R4/R8/R10 read sweep
    do_cmd_read(8'hA0, 32);
    for (int i = 0; i < 32; i++) chk($sformatf("R4 R10 read addr %0h", i), rxb[i], exp_rd(i));

    // R3 repeated-byte write, R7 read without command
    txb[0] = 8'h84; txb[1] = 8'h11; txb[2] = 8'h22; txb[3] = 8'h33;
    do_write(4);
    mdl[4] = 8'h33;
    chk("R3 repeated write target", thr_lo_o[7:0], 8'h33);
    chk("R3 neighbour untouched", thr_lo_o[15:8], mdl[5]);
    do_read(3);
    for (int i = 0; i < 3; i++) chk("R3 R7 repeated read", rxb[i], 8'h33);

    // R6 first byte with bit 7 clear is data
    txb[0] = 8'h5A;
    do_write(1);
    mdl[4] = 8'h5A;
    chk("R6 data at pointer", thr_lo_o[7:0], 8'h5A);

    // R5 special functions
    c0 = n_clr;
    txb[0] = 8'hE6; do_write(1);
    chk("R5 clear pulse count", n_clr - c0, 1);
    txb[0] = 8'hE0; do_write(1);
    chk("R5 no-op no pulse", n_clr - c0, 1);
    txb[0] = 8'hC1; do_write(1);
    chk("R5 reserved no pulse", n_clr - c0, 1);
    do_read(1);
    chk("R5 R7 pointer kept", rxb[0], 8'h5A);
    chk_ports("R5 no register change");

    // R8 shadow latches
    txb[0] = 8'hB4; do_write(1);
    do_read(1);
    chk("R8 ch0 low", rxb[0], 8'hEF);
    ch0 = 16'h7788;
    do_read(1);
    chk("R8 ch0 shadow high", rxb[0], 8'hBE);
    txb[0] = 8'hB6; do_write(1);
    do_read(1);
    chk("R8 ch1 low", rxb[0], 8'h34);
    ch1 = 16'h5566;
    do_read(1);
    chk("R8 ch1 shadow high", rxb[0], 8'h12);
    do_cmd_read(8'hB4, 2);
    chk("R8 fresh low", rxb[0], 8'h88);
    chk("R8 fresh high", rxb[1], 8'h77);

    // R10 status bits follow inputs
    aint = 1'b0; avalid = 1'b1;
    do_cmd_read(8'h93, 1);
    chk("R10 status", rxb[0], 8'h01);
    aint = 1'b1; avalid = 1'b0;
    do_read(1);
    chk("R10 status", rxb[0], 8'h10);

    // R1 mismatched address leaves registers untouched
    i2c_start();
    send_byte({7'h3A, 1'b0}, ack);
    chk("R1 other address nack", ack, 1'b0);
    send_byte(8'h80, ack);
    send_byte(8'h55, ack);
    i2c_stop();
    chk_ports("R1 no write on other address");

    // R11 start pulses and release after stop
    s0 = n_start;
    do_cmd_read(8'h80, 1);
    chk("R11 start pulses", n_start - s0, 2);
    chk("R11 released after stop", sda_oe, 1'b0);
    chk("R11 R2 command read enable", rxb[0], mdl[0]);

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

endmodule